// File: doc/BRIEF.md
# Multi-Format Integer Divide Unit

This block is an iterative integer divider for a 32-bit processor datapath. One shared restoring core produces a quotient magnitude and a remainder magnitude. A formatting stage then gives one of three results. The first is a packed word-form result: a 32-bit dividend divided by a 16-bit divisor, with the 16-bit remainder and the 16-bit quotient side by side in one word. The second is a 32-by-32 quotient. The third is a 32-by-32 remainder for a separate destination register. Each format can run signed or unsigned.

The surrounding pipeline pulses `start` with the operands, the format select and the sign select. It then waits for the single-cycle `done` pulse. At that pulse it takes `result` and the condition flags, and it writes the result only when `res_valid` is high. The core resolves one quotient bit per clock, so a division that is accepted completes in a fixed number of cycles whatever the operands. A zero divisor is reported at once and the core does not run.

Top module: `int_div_unit`

## Requirements
- R1: With `op` = 2'b00 (word form), unsigned: the divisor is `divisor[15:0]` zero-extended, and `result` = {remainder[15:0], quotient[15:0]}.
- R2: With `op` = 2'b01 (long form, 32 by 32), `result` is the 32-bit quotient. `op` = 2'b11 behaves exactly like 2'b01.
- R3: With `op` = 2'b10 (remainder form, 32 by 32), `result` is the 32-bit remainder.
- R4: With `is_signed` = 1, the operands are two's complement and the word-form divisor is `divisor[15:0]` sign-extended. The quotient truncates toward zero and the remainder takes the sign of the dividend. The long-form case of the most negative dividend divided by -1 returns 32'h8000_0000.
- R5: A zero divisor (`divisor[15:0]` in word form, all 32 bits otherwise) gives `done` and `div_zero` one rising edge after `start` is sampled, with `res_valid` low, `busy` staying low, and N, Z, V cleared.
- R6: In word form, a quotient outside 0..65535 (unsigned) or outside -32768..32767 (signed) sets `flag_v`, clears N and Z, and keeps `res_valid` low. Otherwise `flag_v` is 0.
- R7: On a valid result, `flag_n` is the sign bit and `flag_z` is the zero test of the quotient (bit 15 and bits 15:0 in word form) or of the remainder in remainder form. `flag_c` is always 0.
- R8: For a nonzero divisor, `busy` is high from the edge that samples `start` until `done`. `done` is high for exactly one cycle, 34 rising edges (data width + 2) after the sampling edge, and `done` and `busy` are never high together.
- R9: While `busy` is high, `start` and any change of operands or selects are ignored: the result and the latency are those of the division already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled when idle |
| op | input | 2 | Format: 00 word, 01 long quotient, 10 remainder, 11 as 01 |
| is_signed | input | 1 | 1 selects two's complement operation |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor (low half only in word form) |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | With done: result may be written |
| div_zero | output | 1 | With done: divisor was zero |
| result | output | 32 | Formatted result, held between completions |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Word-form overflow flag |
| flag_c | output | 1 | Carry flag, always 0 |

## Verification
The hardest condition to reach from the ports is a new `start` with different operands arriving in the middle of a division. It can only be shown as harmless by the result and the latency of the first division, not by anything the second request leaves behind. The bench raises `start` with unrelated operands and a different format a few cycles into a busy period. It then checks that the completed result, the flags and the 34-edge latency all still belong to the first request. Signed word-form overflow at the edges of the 16-bit range is also targeted directly: the bench uses a dividend and divisor pair whose quotient is exactly -32768, and another whose quotient is -65536.

// File: rtl/idu_pkg.sv
package idu_pkg;
  typedef enum logic [1:0] {
    OP_WORD = 2'b00,
    OP_LONG = 2'b01,
    OP_REM  = 2'b10,
    OP_ALT  = 2'b11
  } idu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } idu_state_e;
endpackage

// File: rtl/idu_core.sv
module idu_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   trial, diff;
  logic         fits;

  // restoring step: shift in the next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_mag;
      dvs_q <= dvs_mag;
    end else if (step) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo_mag = quo_q;
  assign rem_mag = rem_q;
endmodule

// File: rtl/idu_fmt.sv
module idu_fmt
  import idu_pkg::*;
#(
  parameter int W = 32
) (
  input  idu_op_e      op,
  input  logic         sgn,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  output logic [W-1:0] res,
  output logic         ok,
  output logic         fn,
  output logic         fz,
  output logic         fv
);
  localparam int H = W / 2;

  function automatic logic [W-1:0] signed_val(input logic [W-1:0] m, input logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  // magnitude limit of a half-width quotient
  function automatic logic half_fits(input logic [W-1:0] m, input logic s, input logic neg);
    logic [W-1:0] lim;
    if (!s)      lim = {{H{1'b0}}, {H{1'b1}}};
    else if (neg) lim = {{H{1'b0}}, 1'b1, {(H-1){1'b0}}};
    else         lim = {{H{1'b0}}, 1'b0, {(H-1){1'b1}}};
    return m <= lim;
  endfunction

  logic [W-1:0] q_s, r_s;

  always_comb begin
    q_s = signed_val(quo_mag, neg_q);
    r_s = signed_val(rem_mag, neg_r);
    res = q_s;
    ok  = 1'b1;
    fv  = 1'b0;
    fn  = q_s[W-1];
    fz  = (q_s == '0);
    case (op)
      OP_WORD: begin
        res = {r_s[H-1:0], q_s[H-1:0]};
        fn  = q_s[H-1];
        fz  = (q_s[H-1:0] == '0);
        if (!half_fits(quo_mag, sgn, neg_q)) begin
          ok = 1'b0;
          fv = 1'b1;
          fn = 1'b0;
          fz = 1'b0;
        end
      end
      OP_REM: begin
        res = r_s;
        fn  = r_s[W-1];
        fz  = (r_s == '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import idu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic              div_zero,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  localparam int H  = DATA_W / 2;
  localparam int CW = $clog2(DATA_W + 1);

  idu_state_e        state;
  logic [CW-1:0]     cnt;
  idu_op_e           op_in, op_q;
  logic              sgn_q, negq_q, negr_q;
  logic [DATA_W-1:0] dvs_eff, dvd_mag, dvs_mag, quo_mag, rem_mag;
  logic              neg_a, neg_b, zero_in;
  logic              accept_evt, zero_evt, load_evt, step_evt, fin_evt;
  logic [DATA_W-1:0] f_res;
  logic              f_ok, f_n, f_z, f_v;
  logic              done_q, valid_q, dz_q, n_q, z_q, v_q;
  logic [DATA_W-1:0] res_q;

  assign op_in = idu_op_e'(op);

  always_comb begin
    if (op_in == OP_WORD)
      dvs_eff = is_signed ? {{H{divisor[H-1]}}, divisor[H-1:0]}
                          : {{H{1'b0}}, divisor[H-1:0]};
    else
      dvs_eff = divisor;
    zero_in = (dvs_eff == '0);
    neg_a   = is_signed & dividend[DATA_W-1];
    neg_b   = is_signed & dvs_eff[DATA_W-1];
    dvd_mag = neg_a ? (~dividend + 1'b1) : dividend;
    dvs_mag = neg_b ? (~dvs_eff + 1'b1) : dvs_eff;
  end

  // named events for the checker
  assign accept_evt = (state == ST_IDLE) && start;
  assign zero_evt   = accept_evt && zero_in;
  assign load_evt   = accept_evt && !zero_in;
  assign step_evt   = (state == ST_RUN);
  assign fin_evt    = (state == ST_FIN);

  idu_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .step(step_evt),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  idu_fmt #(.W(DATA_W)) u_fmt (
    .op(op_q), .sgn(sgn_q), .neg_q(negq_q), .neg_r(negr_q),
    .quo_mag(quo_mag), .rem_mag(rem_mag),
    .res(f_res), .ok(f_ok), .fn(f_n), .fz(f_z), .fv(f_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      op_q   <= OP_WORD;
      sgn_q  <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (load_evt) begin
          state  <= ST_RUN;
          cnt    <= CW'(DATA_W);
          op_q   <= op_in;
          sgn_q  <= is_signed;
          negq_q <= neg_a ^ neg_b;
          negr_q <= neg_a;
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      dz_q    <= 1'b0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
      v_q     <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q  <= zero_evt || fin_evt;
      valid_q <= fin_evt && f_ok;
      dz_q    <= zero_evt;
      if (zero_evt) begin
        n_q <= 1'b0;
        z_q <= 1'b0;
        v_q <= 1'b0;
      end else if (fin_evt) begin
        n_q <= f_n;
        z_q <= f_z;
        v_q <= f_v;
        if (f_ok) res_q <= f_res;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign res_valid = valid_q;
  assign div_zero  = dz_q;
  assign result    = res_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
  assign flag_v    = v_q;
  assign flag_c    = 1'b0;
endmodule

// File: rtl/idu_checker.sv
module idu_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic res_valid,
  input logic div_zero,
  input logic flag_v,
  input logic step_evt,
  input logic zero_evt
);
  p_zero_novalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (done && !res_valid));
  p_zero_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (done && div_zero && !busy));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v |-> !res_valid);
  p_valid_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_step_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> busy);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || (done && !div_zero)));
endmodule

bind int_div_unit idu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_valid(res_valid), .div_zero(div_zero), .flag_v(flag_v),
  .step_evt(step_evt), .zero_evt(zero_evt)
);

// File: tb/int_div_unit_tb.sv
module int_div_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, res_valid, div_zero, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  int_div_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .res_valid(res_valid), .div_zero(div_zero), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [1:0] o, input logic s, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] res, output bit val,
                       output bit dz, output bit n, output bit z, output bit v);
    longint la, lb, q, r;
    dz = (o == 2'b00) ? (b[15:0] == 16'h0) : (b == 32'h0);
    val = 0; n = 0; z = 0; v = 0; res = '0;
    if (dz) return;
    if (s) begin
      la = longint'($signed(a));
      lb = (o == 2'b00) ? longint'($signed(b[15:0])) : longint'($signed(b));
    end else begin
      la = longint'({32'h0, a});
      lb = (o == 2'b00) ? longint'({48'h0, b[15:0]}) : longint'({32'h0, b});
    end
    q = la / lb;
    r = la % lb;
    val = 1;
    if (o == 2'b00) begin
      if (s ? (q < -32768 || q > 32767) : (q > 65535)) begin
        val = 0; v = 1;
        return;
      end
      res = {r[15:0], q[15:0]};
      n = q[15];
      z = (q[15:0] == 16'h0);
    end else begin
      res = (o == 2'b10) ? r[31:0] : q[31:0];
      n = res[31];
      z = (res == 32'h0);
    end
  endtask

  // launch one division; optionally disturb it while busy
  task automatic run(input string tag, input logic [1:0] o, input logic s,
                     input logic [31:0] a, input logic [31:0] b, input bit disturb);
    logic [31:0] eres, prev;
    bit eval, edz, en, ez, ev;
    int lat;
    bit saw_busy_low;
    model(o, s, a, b, eres, eval, edz, en, ez, ev);
    prev = result;
    @(negedge clk);
    op = o; is_signed = s; dividend = a; divisor = b; start = 1'b1;
    lat = 0;
    saw_busy_low = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (disturb && lat == 5) begin
        start = 1'b1; op = ~o; is_signed = ~s;
        dividend = 32'h0BAD_F00D; divisor = 32'h3;
      end
      if (done) break;
      if (!busy) saw_busy_low = 1;
      if (lat > 100) break;
    end
    start = 1'b0;
    chk({tag, " R8 done latency"}, lat, edz ? 1 : 34);
    chk({tag, " R8 busy held"}, saw_busy_low, 0);
    chk({tag, " R8 busy low at done"}, busy, 0);
    chk({tag, " R5 div_zero"}, div_zero, edz);
    chk({tag, " R6 valid"}, res_valid, eval);
    chk({tag, " R6 flag_v"}, flag_v, ev);
    chk({tag, " R7 flag_n"}, flag_n, en);
    chk({tag, " R7 flag_z"}, flag_z, ez);
    chk({tag, " R7 flag_c"}, flag_c, 0);
    chk({tag, " result"}, result, eval ? eres : prev);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    chk("reset result", result, 0);
    chk("reset R7 flags", {flag_n, flag_z, flag_v, flag_c}, 0);
  endtask

  task automatic t_word_unsigned();
    run("R1 word 100000/7", 2'b00, 0, 32'd100000, 32'hFFFF_0007, 0);
    run("R1 word max", 2'b00, 0, 32'hFFFE_0001, 32'h0000_FFFF, 0);
    run("R7 word zero quotient", 2'b00, 0, 32'd3, 32'd5, 0);
  endtask

  task automatic t_long();
    run("R2 long", 2'b01, 0, 32'hFFFF_FFFF, 32'h0000_0010, 0);
    run("R2 long equal", 2'b01, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run("R2 alt code", 2'b11, 0, 32'd1000, 32'd33, 0);
  endtask

  task automatic t_rem();
    run("R3 rem", 2'b10, 0, 32'hDEAD_BEEF, 32'h0001_2345, 0);
    run("R3 rem zero", 2'b10, 0, 32'd99, 32'd9, 0);
  endtask

  task automatic t_signed();
    run("R4 word -100/7", 2'b00, 1, -32'sd100, 32'd7, 0);
    run("R4 long 7/-2", 2'b01, 1, 32'd7, -32'sd2, 0);
    run("R4 rem -7/2", 2'b10, 1, -32'sd7, 32'd2, 0);
    run("R4 long min/-1", 2'b01, 1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run("R4 word -65536/2 fits", 2'b00, 1, -32'sd65536, 32'd2, 0);
    run("R4 word neg divisor", 2'b00, 1, 32'd1000, 32'h0000_FFF6, 0);
  endtask

  task automatic t_zero();
    run("R5 word zero low half", 2'b00, 0, 32'd5, 32'h1234_0000, 0);
    run("R5 long zero", 2'b01, 1, 32'd5, 32'h0, 0);
  endtask

  task automatic t_overflow();
    run("R6 word unsigned ovf", 2'b00, 0, 32'h1234_5678, 32'd2, 0);
    run("R6 word signed ovf", 2'b00, 1, 32'd65536, 32'hFFFF_FFFF, 0);
    run("R6 word signed ovf pos", 2'b00, 1, 32'd32768, 32'd1, 0);
  endtask

  task automatic t_ignore();
    run("R9 start while busy", 2'b01, 0, 32'd123456789, 32'd1000, 1);
    run("R9 start while busy word", 2'b00, 1, -32'sd5000, 32'd9, 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_unsigned();
    t_long();
    t_rem();
    t_signed();
    t_zero();
    t_overflow();
    t_ignore();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule